// File: doc/BRIEF.md
# Transaction Security Firewall Gate

This block stands between bus initiators and a fixed set of addressed targets and rules on every transaction before it reaches a target. Each target belongs to either a secure or a non-secure zone. A secure transaction may reach any target. A non-secure transaction may reach only non-secure targets. Addresses that fall in no region are refused with a decode error. A small security control register holds one zone bit per target. Only a secure transaction may read or write it. After reset every target is secure.

The security level of a transaction comes from the attribute carried with the request, unless a system-management port has forced a level for that initiator. At reset every initiator is forced, and a parameter picks which initiators start secure. The verdict is registered. A small response state machine turns it into a response one cycle after the request. The machine has four states. ST_IDLE means no response. ST_OKAY means granted. ST_SECERR means refused for security and raises the violation pulse. ST_DECERR means no region matched. Every cycle the machine moves to the state chosen by the current request, and it returns to ST_IDLE when no request is present.

Top module: `sec_fw_gate`

## Requirements
- R1: After reset, rsp_valid and viol_pulse are 0, every zone bit is 0 (secure), and every initiator is forced to the level given by bit i of INIT_SEC_RST (default 4'b0101: initiators 0 and 2 secure, 1 and 3 non-secure).
- R2: A request with req_valid=1 produces rsp_valid=1 in exactly the next cycle. A cycle with no request produces rsp_valid=0 in the next cycle.
- R3: A transaction whose effective level is secure is granted (rsp_code 2'b00) on any mapped target and on the control register.
- R4: A non-secure transaction to a target whose zone bit is 0 is refused with rsp_code 2'b10.
- R5: A non-secure transaction to a target whose zone bit is 1 is granted with rsp_code 2'b00.
- R6: An address that matches no region is answered with rsp_code 2'b11 at any security level, without a violation pulse. Target t occupies the 4 KiB page at 0x4000_0000 + t*0x1000 for t < N_TGT. The control register is the single word at 0x5000_0000, and any other offset in that page is unmapped.
- R7: A granted write to the control register loads req_wdata into the zone bits, where bit t set to 1 puts target t in the non-secure zone. A granted read returns the zone bits on rsp_rdata. rsp_rdata is 0 in every other case.
- R8: A non-secure read or write of the control register is refused with rsp_code 2'b10 and leaves the zone bits unchanged.
- R9: Every refusal for security raises viol_pulse for that response cycle only. viol_id carries the initiator and viol_tgt carries the target index, which is N_TGT for the control register.
- R10: When an initiator is forced, its transactions take the forced level and req_sec is ignored. When it is released, req_sec decides.
- R11: A management write in the same cycle as a request from that initiator leaves that request judged by the old setting. The new setting applies from the next cycle.
- R12: A control-register write takes effect for an access issued in the next cycle.
- R13: rsp_tgt reports the decoded target index: t for target t, N_TGT for the control register, and 0 for an unmapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_id | input | ID_W | Issuing initiator |
| req_addr | input | ADDR_W | Request address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_sec | input | 1 | Per-transaction secure attribute |
| req_wdata | input | N_TGT | Write data for the control register |
| mgmt_we | input | 1 | Management update strobe |
| mgmt_id | input | ID_W | Initiator being configured |
| mgmt_force | input | 1 | 1 = force level, 0 = use req_sec |
| mgmt_level | input | 1 | Forced level (1 = secure) |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 00 granted, 10 security error, 11 decode error |
| rsp_tgt | output | TI_W | Decoded target index |
| rsp_rdata | output | N_TGT | Zone bits on a granted control read |
| viol_pulse | output | 1 | One-cycle security violation flag |
| viol_id | output | ID_W | Violating initiator |
| viol_tgt | output | TI_W | Target of the violation |

## Verification
Two pairs of events can fall in the same cycle. In the first pair, a management write that releases an initiator's forced level arrives together with a request from that initiator. The bench drives both at the same edge and expects the refusal that the old forced level dictates, then expects a grant from the released attribute one cycle later. In the second pair, a secure control-register write is followed by a non-secure access in the very next cycle. The scoreboard's model updates its zone copy only after it has queued the writer's expected response, so the back-to-back access is judged against the new zone.

// File: rtl/sec_fw_pkg.sv
package sec_fw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OKAY   = 2'd1,
        ST_SECERR = 2'd2,
        ST_DECERR = 2'd3
    } rsp_state_e;

    localparam logic [1:0] RC_OKAY   = 2'b00;
    localparam logic [1:0] RC_SECERR = 2'b10;
    localparam logic [1:0] RC_DECERR = 2'b11;

endpackage

// File: rtl/sec_fw_decode.sv
module sec_fw_decode #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned N_TGT     = 4,
    parameter int unsigned PAGE_LOG2 = 12,
    parameter int unsigned TI_W      = 3,
    parameter logic [ADDR_W-1:0] TGT_BASE = 32'h4000_0000,
    parameter logic [ADDR_W-1:0] SCR_BASE = 32'h5000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_TGT-1:0]  hit_vec,
    output logic              tgt_hit,
    output logic [TI_W-1:0]   tgt_idx,
    output logic              scr_hit
);
    localparam int unsigned PAGE_W = ADDR_W - PAGE_LOG2;
    localparam logic [PAGE_W-1:0] TGT_PAGE = TGT_BASE[ADDR_W-1:PAGE_LOG2];
    localparam logic [PAGE_W-1:0] SCR_PAGE = SCR_BASE[ADDR_W-1:PAGE_LOG2];

    logic [PAGE_W-1:0]    page;
    logic [PAGE_LOG2-1:0] offset;

    assign page   = addr[ADDR_W-1:PAGE_LOG2];
    assign offset = addr[PAGE_LOG2-1:0];

    // One page comparator per target region
    for (genvar t = 0; t < N_TGT; t++) begin : g_region
        assign hit_vec[t] = (page == (TGT_PAGE + PAGE_W'(t)));
    end

    assign tgt_hit = |hit_vec;

    always_comb begin
        tgt_idx = '0;
        for (int t = 0; t < N_TGT; t++) begin
            if (hit_vec[t]) begin
                tgt_idx = TI_W'(t);
            end
        end
    end

    // Control register: a single word at the page base
    assign scr_hit = (page == SCR_PAGE) && (offset == '0);

endmodule

// File: rtl/sec_fw_zone_regs.sv
module sec_fw_zone_regs #(
    parameter int unsigned N_TGT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [N_TGT-1:0] wr_data,
    output logic [N_TGT-1:0] zone_q
);
    // Bit t = 1: target t non-secure. Reset: everything secure.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zone_q <= '0;
        end else if (wr_en) begin
            zone_q <= wr_data;
        end
    end

endmodule

// File: rtl/sec_fw_init_sec.sv
module sec_fw_init_sec #(
    parameter int unsigned N_INIT = 4,
    parameter int unsigned ID_W   = 2,
    parameter logic [N_INIT-1:0] RST_LEVEL = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mgmt_we,
    input  logic [ID_W-1:0]   mgmt_id,
    input  logic              mgmt_force,
    input  logic              mgmt_level,
    output logic [N_INIT-1:0] force_vec,
    output logic [N_INIT-1:0] level_vec
);
    for (genvar i = 0; i < N_INIT; i++) begin : g_init
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                force_vec[i] <= 1'b1;
                level_vec[i] <= RST_LEVEL[i];
            end else if (mgmt_we && (mgmt_id == ID_W'(i))) begin
                force_vec[i] <= mgmt_force;
                level_vec[i] <= mgmt_level;
            end
        end
    end

endmodule

// File: rtl/sec_fw_gate.sv
module sec_fw_gate
    import sec_fw_pkg::*;
#(
    parameter int unsigned N_INIT    = 4,
    parameter int unsigned N_TGT     = 4,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned PAGE_LOG2 = 12,
    parameter logic [ADDR_W-1:0] TGT_BASE = 32'h4000_0000,
    parameter logic [ADDR_W-1:0] SCR_BASE = 32'h5000_0000,
    parameter logic [N_INIT-1:0] INIT_SEC_RST = 4'b0101,
    localparam int unsigned ID_W = (N_INIT > 1) ? $clog2(N_INIT) : 1,
    localparam int unsigned TI_W = $clog2(N_TGT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ID_W-1:0]   req_id,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic              req_sec,
    input  logic [N_TGT-1:0]  req_wdata,
    input  logic              mgmt_we,
    input  logic [ID_W-1:0]   mgmt_id,
    input  logic              mgmt_force,
    input  logic              mgmt_level,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [TI_W-1:0]   rsp_tgt,
    output logic [N_TGT-1:0]  rsp_rdata,
    output logic              viol_pulse,
    output logic [ID_W-1:0]   viol_id,
    output logic [TI_W-1:0]   viol_tgt
);
    localparam logic [TI_W-1:0] SCR_IDX = TI_W'(N_TGT);

    logic [N_TGT-1:0]  hit_vec;
    logic              tgt_hit;
    logic [TI_W-1:0]   tgt_idx;
    logic              scr_hit;
    logic [N_TGT-1:0]  zone_q;
    logic              zone_we;
    logic [N_INIT-1:0] force_vec;
    logic [N_INIT-1:0] level_vec;
    logic              eff_sec;

    rsp_state_e        state_q, state_d;
    logic [ID_W-1:0]   id_q;
    logic [TI_W-1:0]   tgt_q, tgt_d;
    logic [N_TGT-1:0]  rdata_q, rdata_d;

    sec_fw_decode #(
        .ADDR_W    (ADDR_W),
        .N_TGT     (N_TGT),
        .PAGE_LOG2 (PAGE_LOG2),
        .TI_W      (TI_W),
        .TGT_BASE  (TGT_BASE),
        .SCR_BASE  (SCR_BASE)
    ) u_decode (
        .addr    (req_addr),
        .hit_vec (hit_vec),
        .tgt_hit (tgt_hit),
        .tgt_idx (tgt_idx),
        .scr_hit (scr_hit)
    );

    sec_fw_zone_regs #(
        .N_TGT (N_TGT)
    ) u_zone (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (zone_we),
        .wr_data (req_wdata),
        .zone_q  (zone_q)
    );

    sec_fw_init_sec #(
        .N_INIT    (N_INIT),
        .ID_W      (ID_W),
        .RST_LEVEL (INIT_SEC_RST)
    ) u_init (
        .clk        (clk),
        .rst_n      (rst_n),
        .mgmt_we    (mgmt_we),
        .mgmt_id    (mgmt_id),
        .mgmt_force (mgmt_force),
        .mgmt_level (mgmt_level),
        .force_vec  (force_vec),
        .level_vec  (level_vec)
    );

    // Forced level wins over the per-transaction attribute
    assign eff_sec = force_vec[req_id] ? level_vec[req_id] : req_sec;

    // Verdict and next response state
    always_comb begin
        state_d = ST_IDLE;
        zone_we = 1'b0;
        tgt_d   = '0;
        rdata_d = '0;
        if (req_valid) begin
            if (scr_hit) begin
                tgt_d = SCR_IDX;
                if (eff_sec) begin
                    state_d = ST_OKAY;
                    zone_we = req_we;
                    if (!req_we) begin
                        rdata_d = zone_q;
                    end
                end else begin
                    state_d = ST_SECERR;
                end
            end else if (tgt_hit) begin
                tgt_d = tgt_idx;
                if (eff_sec || |(hit_vec & zone_q)) begin
                    state_d = ST_OKAY;
                end else begin
                    state_d = ST_SECERR;
                end
            end else begin
                state_d = ST_DECERR;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Response payload captured with the verdict
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q    <= '0;
            tgt_q   <= '0;
            rdata_q <= '0;
        end else begin
            id_q    <= req_id;
            tgt_q   <= tgt_d;
            rdata_q <= rdata_d;
        end
    end

    // Outputs from the response state
    always_comb begin
        rsp_valid  = 1'b0;
        rsp_code   = RC_OKAY;
        viol_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                rsp_valid = 1'b0;
            end
            ST_OKAY: begin
                rsp_valid = 1'b1;
                rsp_code  = RC_OKAY;
            end
            ST_SECERR: begin
                rsp_valid  = 1'b1;
                rsp_code   = RC_SECERR;
                viol_pulse = 1'b1;
            end
            ST_DECERR: begin
                rsp_valid = 1'b1;
                rsp_code  = RC_DECERR;
            end
            default: begin
                rsp_valid = 1'b0;
            end
        endcase
    end

    assign rsp_tgt   = rsp_valid ? tgt_q : '0;
    assign rsp_rdata = rsp_valid ? rdata_q : '0;
    assign viol_id   = viol_pulse ? id_q : '0;
    assign viol_tgt  = viol_pulse ? tgt_q : '0;

endmodule

// File: rtl/sec_fw_gate_chk.sv
module sec_fw_gate_chk #(
    parameter int unsigned N_TGT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             rsp_valid,
    input logic [1:0]       rsp_code,
    input logic             viol_pulse,
    input logic             eff_sec,
    input logic             scr_hit,
    input logic             tgt_hit,
    input logic [N_TGT-1:0] zone_q
);
    p_resp_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_secure_granted_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && eff_sec && (scr_hit || tgt_hit)) |=> (rsp_code == 2'b00));

    p_unmapped_decerr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !scr_hit && !tgt_hit) |=> (rsp_code == 2'b11 && !viol_pulse));

    p_scr_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && scr_hit && !eff_sec) |=> $stable(zone_q));

    p_viol_is_secerr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse |-> (rsp_valid && rsp_code == 2'b10));

endmodule

bind sec_fw_gate sec_fw_gate_chk #(.N_TGT(N_TGT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .rsp_code   (rsp_code),
    .viol_pulse (viol_pulse),
    .eff_sec    (eff_sec),
    .scr_hit    (scr_hit),
    .tgt_hit    (tgt_hit),
    .zone_q     (zone_q)
);

// File: tb/sec_fw_gate_tb.sv
`timescale 1ns/1ps
module sec_fw_gate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_id = '0;
    logic [31:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic        req_sec = 1'b0;
    logic [3:0]  req_wdata = '0;
    logic        mgmt_we = 1'b0;
    logic [1:0]  mgmt_id = '0;
    logic        mgmt_force = 1'b0;
    logic        mgmt_level = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic [2:0]  rsp_tgt;
    logic [3:0]  rsp_rdata;
    logic        viol_pulse;
    logic [1:0]  viol_id;
    logic [2:0]  viol_tgt;

    always #2 clk = ~clk;   // 250 MHz

    sec_fw_gate u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_id(req_id), .req_addr(req_addr),
        .req_we(req_we), .req_sec(req_sec), .req_wdata(req_wdata),
        .mgmt_we(mgmt_we), .mgmt_id(mgmt_id), .mgmt_force(mgmt_force),
        .mgmt_level(mgmt_level),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_tgt(rsp_tgt),
        .rsp_rdata(rsp_rdata), .viol_pulse(viol_pulse), .viol_id(viol_id),
        .viol_tgt(viol_tgt)
    );

    typedef struct {
        logic [1:0] code;
        logic [2:0] tgt;
        logic [3:0] rdata;
        logic       viol;
        logic [1:0] vid;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    // Reference model state, built from the requirements
    logic [3:0] m_zone  = 4'b0000;
    logic [3:0] m_force = 4'b1111;
    logic [3:0] m_level = 4'b0101;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic issue_m(input logic [1:0] id, input logic [31:0] addr,
                           input logic we, input logic sec, input logic [3:0] wd,
                           input logic mwe, input logic [1:0] mid,
                           input logic mf, input logic ml, input string tag);
        exp_t e;
        logic eff;
        logic [19:0] page;
        bit is_scr;
        bit is_tgt;
        int t;
        @(negedge clk);
        req_valid = 1'b1; req_id = id; req_addr = addr; req_we = we;
        req_sec = sec; req_wdata = wd;
        mgmt_we = mwe; mgmt_id = mid; mgmt_force = mf; mgmt_level = ml;
        eff    = m_force[id] ? m_level[id] : sec;
        page   = addr[31:12];
        is_scr = (addr == 32'h5000_0000);
        is_tgt = (page >= 20'h40000) && (page < 20'h40004);
        e.tag = tag; e.rdata = '0; e.viol = 1'b0; e.vid = '0; e.tgt = '0;
        e.code = 2'b11;
        if (is_scr) begin
            e.tgt = 3'd4;
            if (eff) begin
                e.code = 2'b00;
                if (!we) e.rdata = m_zone;
            end else begin
                e.code = 2'b10; e.viol = 1'b1; e.vid = id;
            end
        end else if (is_tgt) begin
            t = int'(page - 20'h40000);
            e.tgt = 3'(t);
            if (eff || m_zone[t]) begin
                e.code = 2'b00;
            end else begin
                e.code = 2'b10; e.viol = 1'b1; e.vid = id;
            end
        end
        q.push_back(e);
        if (is_scr && eff && we) m_zone = wd;
        if (mwe) begin
            m_force[mid] = mf;
            m_level[mid] = ml;
        end
    endtask

    task automatic issue(input logic [1:0] id, input logic [31:0] addr,
                         input logic we, input logic sec, input logic [3:0] wd,
                         input string tag);
        issue_m(id, addr, we, sec, wd, 1'b0, 2'd0, 1'b0, 1'b0, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            mgmt_we   = 1'b0;
        end
    endtask

    // Monitor: pop and compare each response
    always @(negedge clk) begin
        if (rst_n && !done && rsp_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R2", "unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(rsp_code == e.code, e.tag, "rsp_code", rsp_code, e.code);
                chk(rsp_tgt == e.tgt, {e.tag, "/R13"}, "rsp_tgt", rsp_tgt, e.tgt);
                chk(rsp_rdata == e.rdata, e.tag, "rsp_rdata", rsp_rdata, e.rdata);
                chk(viol_pulse == e.viol && viol_id == e.vid &&
                    viol_tgt == (e.viol ? e.tgt : 3'd0), {e.tag, "/R9"},
                    "violation", {viol_pulse, viol_id, viol_tgt},
                    {e.viol, e.vid, (e.viol ? e.tgt : 3'd0)});
            end
        end
    end

    initial begin
        #80000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        chk(rsp_valid == 1'b0 && viol_pulse == 1'b0, "R1", "idle outputs",
            {rsp_valid, viol_pulse}, 0);

        issue(2'd0, 32'h4000_1000, 1'b0, 1'b0, 4'h0, "R3 secure forced id0");
        issue(2'd1, 32'h4000_0000, 1'b0, 1'b1, 4'h0, "R1/R4/R10 id1 forced ns");
        issue(2'd1, 32'h5000_0000, 1'b0, 1'b1, 4'h0, "R8 ns scr read");
        issue(2'd1, 32'h5000_0000, 1'b1, 1'b1, 4'hF, "R8 ns scr write");
        issue(2'd0, 32'h5000_0000, 1'b0, 1'b0, 4'h0, "R8/R7 scr unchanged read");
        issue(2'd0, 32'h5000_0000, 1'b1, 1'b0, 4'b0110, "R7 secure scr write");
        issue(2'd1, 32'h4000_2000, 1'b0, 1'b0, 4'h0, "R12/R5 next-cycle access");
        issue(2'd1, 32'h4000_3000, 1'b0, 1'b0, 4'h0, "R4 ns on secure tgt3");
        issue(2'd0, 32'h4000_4000, 1'b0, 1'b1, 4'h0, "R6 past last target");
        issue(2'd1, 32'h0000_0000, 1'b0, 1'b0, 4'h0, "R6 low unmapped");
        issue(2'd0, 32'h5000_0004, 1'b0, 1'b1, 4'h0, "R6 scr page offset");
        // R11: release id1 in the same cycle as its request
        issue_m(2'd1, 32'h4000_3000, 1'b0, 1'b1, 4'h0, 1'b1, 2'd1, 1'b0, 1'b0,
                "R11 old setting applies");
        issue(2'd1, 32'h4000_3000, 1'b0, 1'b1, 4'h0, "R10/R11 released sec");
        issue(2'd1, 32'h4000_3000, 1'b0, 1'b0, 4'h0, "R10 released ns");
        issue_m(2'd0, 32'h4000_0000, 1'b0, 1'b1, 4'h0, 1'b1, 2'd0, 1'b1, 1'b0,
                "R3 id0 before force");
        issue(2'd0, 32'h4000_0000, 1'b0, 1'b1, 4'h0, "R10 id0 forced ns");
        issue(2'd0, 32'h5000_0000, 1'b0, 1'b1, 4'h0, "R8/R9 forced ns scr");
        issue(2'd3, 32'h4000_1000, 1'b0, 1'b0, 4'h0, "R5 id3 ns open tgt");
        idle(3);
        // R2: all responses arrived, none left pending
        chk(q.size() == 0 && rsp_valid == 1'b0, "R2", "drained",
            q.size(), 0);
        issue(2'd2, 32'h5000_0000, 1'b0, 1'b0, 4'h0, "R7 id2 scr read");
        idle(3);
        chk(q.size() == 0, "R2", "final drain", q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule